// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Generator

This block produces a single pulse-width modulated output from a prescaled up-counter. Each period starts with the output high. The output drops once the counter reaches the active duty value. Software hands new duty values to a four-entry queue through a simple synchronous register port: a write strobe, a word address and write data, with read data returned combinationally for the current address.

A queued duty value is moved into the active compare register only when a period begins. That is either the first cycle after the generator is enabled or the cycle in which the counter wraps. This holds even when the queue is empty, so a duty write can never land in the middle of a period. Lowering the duty below the present count therefore cannot leave a period without its falling edge.

The period lasts the programmed period value plus two counter ticks. A counter tick comes every prescale-value-plus-one clocks. When the queue is empty at a period start, the previous duty value stays in use.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After reset `pwm_o` is low, the counter register reads 0 and the status register reads 16: fill 0, low-level flag set, overflow clear.
- R2: With period value P and prescale field D, one period lasts (P+2)*(D+1) clocks. Register addresses: 0 control, 1 status, 2 duty, 3 period, 4 counter. Control bit 0 is enable, bits [2:1] are the watermark and bits [15:4] hold D.
- R3: With active duty S, the output is high for S*(D+1) clocks at the start of each period. S=0 keeps the output low. S at or above P+2 keeps the output high for the whole period.
- R4: A write to address 2 only queues the value. It does not change the active duty (read back at address 2) or the current period, even when it is below the present count. It takes effect at the next period start.
- R5: If the queue is empty at a period start, the previous active duty is used again.
- R6: The queue holds 4 values. A duty write while it is full is dropped and sets the sticky overflow flag, status bit 5. Writing 1 to status bit 5 clears that flag.
- R7: Status bits [3:0] give the queue fill count. Status bit 4 is set when the fill count is less than or equal to the watermark.
- R8: While disabled, the output is low and the counter reads 0. When enabled, the head of the queue becomes the active duty for the first period.
- R9: The counter register reads the current count. The count advances by one every D+1 clocks from 0 at a period start.
- R10: Queued values are applied one per period in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` |
| pwm_o | output | 1 | Modulated output |

## Verification
The hardest situation to create is a duty write that arrives mid-period while the queue is empty, carrying a value below the current count but above zero. The measurement task tracks the clock index inside the period being timed. It drives the lower duty write from that task at a chosen index where the count already exceeds the new value. It then checks that this period still ends at the old duty and that the following periods use the new one. Randomised periods, prescales and duty pairs repeat this at many alignments.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;

    localparam int PWMQ_PRE_W    = 12;
    localparam int STAT_FILL_W   = 4;
    localparam int STAT_LOW_BIT  = 4;
    localparam int STAT_OVF_BIT  = 5;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_STAT = 3'd1,
        REG_SMPL = 3'd2,
        REG_PER  = 3'd3,
        REG_CNT  = 3'd4
    } pwmq_reg_e;

    typedef struct packed {
        logic [PWMQ_PRE_W-1:0] prediv;
        logic [1:0]            mark;
        logic                  en;
    } pwmq_ctrl_t;

    function automatic pwmq_ctrl_t ctrl_from_word(input logic [31:0] w);
        pwmq_ctrl_t c;
        c.en     = w[0];
        c.mark   = w[2:1];
        c.prediv = w[4 +: PWMQ_PRE_W];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input pwmq_ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[0] = c.en;
        w[2:1] = c.mark;
        w[4 +: PWMQ_PRE_W] = c.prediv;
        return w;
    endfunction

endpackage

// File: rtl/pwmq_fifo.sv
module pwmq_fifo #(
    parameter int W      = 16,
    parameter int DEPTH  = 4,
    parameter int FILL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [W-1:0]      din,
    output logic [W-1:0]      dout,
    output logic [FILL_W-1:0] fill,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [FILL_W-1:0] fill_q;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q   <= '0;
            rp_q   <= '0;
            fill_q <= '0;
        end else begin
            if (push) wp_q <= nxt(wp_q);
            if (pop)  rp_q <= nxt(rp_q);
            fill_q <= fill_q + FILL_W'(push) - FILL_W'(pop);
        end
    end

    assign dout  = mem[rp_q];
    assign fill  = fill_q;
    assign full  = (fill_q == FILL_W'(DEPTH));
    assign empty = (fill_q == '0);

    // R6: occupancy never exceeds the queue depth
    assert_fifo_bound_R6: assert property (@(posedge clk) disable iff (rst)
        fill_q <= FILL_W'(DEPTH));

    // R5: the compare side never draws from an empty queue
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R6: a push against a full queue is never attempted
    assert_no_overpush_R6: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> !full);

endmodule

// File: rtl/pwmq_timebase.sv
module pwmq_timebase #(
    parameter int CNT_W = 17,
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PRE_W-1:0] prediv,
    input  logic [CNT_W-1:0] last,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             bnd
);
    logic             run_q;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick, wrap, start;

    assign tick  = run_q && (pre_q >= prediv);
    assign wrap  = tick && (cnt_q >= last);
    assign start = en && !run_q;
    assign bnd   = start || (wrap && en);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            run_q <= en;
            if (!en || start) begin
                pre_q <= '0;
                cnt_q <= '0;
            end else if (tick) begin
                pre_q <= '0;
                cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    assign run = run_q;
    assign cnt = cnt_q;

    // R8: an idle generator holds its counter at zero
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> (cnt_q == '0));

    // R9: a prescaled tick inside a period advances the count by one
    assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !wrap) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R2: the count returns to zero after the last tick of a period
    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (en && wrap) |=> (cnt_q == '0));

endmodule

// File: rtl/pwmq_duty.sv
module pwmq_duty #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              bnd,
    input  logic              empty,
    input  logic [DATA_W-1:0] head,
    input  logic [CNT_W-1:0]  cnt,
    output logic              pop,
    output logic [DATA_W-1:0] active,
    output logic              pwm
);
    logic [DATA_W-1:0] active_q;

    assign pop = bnd && !empty;

    always_ff @(posedge clk) begin
        if (rst)      active_q <= '0;
        else if (pop) active_q <= head;
    end

    assign active = active_q;
    assign pwm    = run && (cnt < CNT_W'(active_q));

    // R4: the active duty only changes at a period start
    assert_hold_mid_period_R4: assert property (@(posedge clk) disable iff (rst)
        !bnd |=> $stable(active_q));

    // R5: an empty queue at a period start keeps the duty
    assert_keep_on_empty_R5: assert property (@(posedge clk) disable iff (rst)
        (bnd && empty) |=> $stable(active_q));

endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
    import pwmq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    parameter int BUS_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             pwm_o
);
    localparam int CNT_W  = DATA_W + 1;
    localparam int FILL_W = $clog2(DEPTH + 1);

    pwmq_ctrl_t        ctrl_q;
    logic [DATA_W-1:0] period_q;
    logic              ovf_q;

    logic wr_ctrl, wr_stat, wr_smpl, wr_per;
    logic push, pop, full, empty, run, bnd, low_flag;
    logic [DATA_W-1:0] head, active;
    logic [FILL_W-1:0] fill;
    logic [CNT_W-1:0]  cnt, last;

    assign wr_ctrl = wr_en && (addr == REG_CTRL);
    assign wr_stat = wr_en && (addr == REG_STAT);
    assign wr_smpl = wr_en && (addr == REG_SMPL);
    assign wr_per  = wr_en && (addr == REG_PER);

    assign push     = wr_smpl && !full;
    assign last     = CNT_W'(period_q) + CNT_W'(1);
    assign low_flag = (fill <= FILL_W'(ctrl_q.mark));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q   <= ctrl_from_word(32'(wdata));
            if (wr_per)  period_q <= wdata[DATA_W-1:0];
            if (wr_smpl && full)                   ovf_q <= 1'b1;
            else if (wr_stat && wdata[STAT_OVF_BIT]) ovf_q <= 1'b0;
        end
    end

    pwmq_fifo #(.W(DATA_W), .DEPTH(DEPTH), .FILL_W(FILL_W)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .din(wdata[DATA_W-1:0]), .dout(head), .fill(fill),
        .full(full), .empty(empty)
    );

    pwmq_timebase #(.CNT_W(CNT_W), .PRE_W(PWMQ_PRE_W)) u_tb (
        .clk(clk), .rst(rst), .en(ctrl_q.en), .prediv(ctrl_q.prediv),
        .last(last), .run(run), .cnt(cnt), .bnd(bnd)
    );

    pwmq_duty #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_duty (
        .clk(clk), .rst(rst), .run(run), .bnd(bnd), .empty(empty),
        .head(head), .cnt(cnt), .pop(pop), .active(active), .pwm(pwm_o)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            REG_CTRL: rdata = BUS_W'(ctrl_to_word(ctrl_q));
            REG_STAT: begin
                rdata[STAT_FILL_W-1:0] = STAT_FILL_W'(fill);
                rdata[STAT_LOW_BIT]    = low_flag;
                rdata[STAT_OVF_BIT]    = ovf_q;
            end
            REG_SMPL: rdata = BUS_W'(active);
            REG_PER:  rdata = BUS_W'(period_q);
            REG_CNT:  rdata = BUS_W'(cnt);
            default:  rdata = '0;
        endcase
    end

    // R6: overflow stays set until software clears it
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !(wr_stat && wdata[STAT_OVF_BIT])) |=> ovf_q);

    // R6: a dropped write leaves the flag set
    assert_ovf_set_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_smpl && full) |=> ovf_q);

endmodule

// File: tb/test_pwm_fifo_gen.sv
module test_pwm_fifo_gen;
    import pwmq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        pwm;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int m_hi [8];
    int m_len [8];

    always #4 clk = ~clk;

    pwm_fifo_gen i_pwm_fifo_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_o(pwm)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input bit en, input int wm, input int pd);
        return {16'd0, 12'(pd), 1'b0, 2'(wm), en};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic wait_rise();
        logic prev, cur;
        int guard;
        prev = pwm; guard = 0;
        forever begin
            @(negedge clk);
            cur = pwm; guard++;
            if (!prev && cur) break;
            prev = cur;
            if (guard > 20000) begin check("rise timeout", 0, 1); return; end
        end
    endtask

    // times n periods; optional duty write at clock index inj_at of the first one
    task automatic measure(input int n, input int inj_at, input int inj_val);
        logic prev, cur;
        wait_rise();
        for (int k = 0; k < n; k++) begin
            m_hi[k] = 1; m_len[k] = 1; prev = 1'b1;
            forever begin
                if (k == 0 && inj_at != 0 && m_len[k] == inj_at) begin
                    wr_en = 1'b1; addr = REG_SMPL; wdata = 32'(inj_val);
                end
                @(negedge clk);
                wr_en = 1'b0;
                cur = pwm;
                if (!prev && cur) break;
                m_len[k]++;
                if (cur) m_hi[k]++;
                prev = cur;
                if (m_len[k] > 20000) begin check("period timeout", 0, 1); return; end
            end
        end
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm) h++;
        end
    endtask

    initial begin
        int v, h, p, d, s, s2, k, wm;
        v = $urandom(32'h5EED);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pwm", int'(pwm), 0);
        rd(REG_CNT, v);  check("R1 count", v, 0);
        rd(REG_STAT, v); check("R1 status", v, 16);

        // R7 / R6 queue status while disabled
        wr(REG_CTRL, cw(0, 2, 0));
        wr(REG_SMPL, 10); wr(REG_SMPL, 20); wr(REG_SMPL, 30);
        rd(REG_STAT, v); check("R7 fill3 above mark", v, 3);
        rd(REG_SMPL, v); check("R4 queued not active", v, 0);
        wr(REG_SMPL, 40);
        wr(REG_SMPL, 50);
        rd(REG_STAT, v); check("R6 overflow on full", v, 4 + 32);
        wr(REG_STAT, 32'h20);
        rd(REG_STAT, v); check("R6 overflow cleared", v, 4);

        // R8 / R10 / R5 / R2: start-up and ordered application
        wr(REG_PER, 60);
        wr(REG_CTRL, cw(1, 2, 0));
        measure(5, 0, 0);
        check("R8 first period duty", m_hi[0], 10);
        check("R2 period length", m_len[0], 62);
        check("R10 order 2nd", m_hi[1], 20);
        check("R10 order 3rd", m_hi[2], 30);
        check("R10 order 4th", m_hi[3], 40);
        check("R5 reuse on empty", m_hi[4], 40);
        check("R6 dropped value absent", m_len[4], 62);

        // R4: lower duty below current count, mid-period, empty queue
        measure(3, 31, 12);
        check("R4 current period keeps old duty", m_hi[0], 40);
        check("R4 next period new duty", m_hi[1], 12);
        check("R5 kept after apply", m_hi[2], 12);

        // R9 counter readback with prescale 4
        wr(REG_CTRL, cw(1, 2, 3));
        for (int t = 0; t < 3; t++) begin
            wait_rise();
            wait_rise();
            k = 1 + int'($urandom % 200);
            repeat (k) @(negedge clk);
            rd(REG_CNT, v);
            check("R9 count value", v, k / 4);
        end

        // R8 disable
        wr(REG_CTRL, cw(0, 0, 0));
        repeat (2) @(negedge clk);
        check("R8 output low when off", int'(pwm), 0);
        rd(REG_CNT, v); check("R8 count zero when off", v, 0);
        count_high(100, h); check("R8 stays low", h, 0);

        // R2 / R3 / R4 randomised
        for (int it = 0; it < 6; it++) begin
            p  = 20 + int'($urandom % 100);
            d  = int'($urandom % 4);
            s  = 2 + int'($urandom % p);
            s2 = 1 + int'($urandom % (s - 1));
            wr(REG_CTRL, cw(0, 0, d));
            wr(REG_PER, 32'(p));
            wr(REG_SMPL, 32'(s));
            wr(REG_CTRL, cw(1, 0, d));
            measure(3, s * (d + 1), s2);
            check("R3 random high time", m_hi[0], s * (d + 1));
            check("R2 random period", m_len[0], (p + 2) * (d + 1));
            check("R4 random lowered duty", m_hi[1], s2 * (d + 1));
            check("R5 random repeat", m_hi[2], s2 * (d + 1));
            wr(REG_CTRL, cw(0, 0, d));
        end

        // R3 zero duty and saturated duty
        wr(REG_CTRL, cw(0, 0, 0));
        wr(REG_PER, 30);
        wr(REG_SMPL, 0);
        wr(REG_CTRL, cw(1, 0, 0));
        count_high(100, h); check("R3 zero duty low", h, 0);
        wr(REG_SMPL, 40);
        repeat (70) @(negedge clk);
        count_high(64, h); check("R3 saturated duty high", h, 64);

        // R7 watermark flag, randomised fill levels
        for (int it = 0; it < 4; it++) begin
            wr(REG_CTRL, cw(0, 0, 0));
            k  = int'($urandom % 5);
            wm = int'($urandom % 4);
            wr(REG_CTRL, cw(0, wm, 0));
            for (int j = 0; j < k; j++) wr(REG_SMPL, 32'(5 + j));
            rd(REG_STAT, v);
            check("R7 fill and low flag", v, k + ((k <= wm) ? 16 : 0));
            wr(REG_PER, 0);
            wr(REG_CTRL, cw(1, wm, 0));
            repeat (20) @(negedge clk);
        end
        wr(REG_CTRL, cw(0, 0, 0));
        rd(REG_STAT, v); check("R7 drained", v, 16);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule